// File: doc/BRIEF.md
# Masked Register Readback Sequencer

This block sits on the control port of a DMA controller and governs how the CPU reads back the controller's status byte and its counter and address registers. Writing a start command byte arms a readback walk. Each later CPU read then returns the next register enabled in a 7-bit read mask, beginning with the lowest-order enabled one. The walk does not have to start right away: any number of idle cycles and unrelated command writes may come before or between the reads.

While a walk is unfinished, a second start command and the status-read command are both dropped. Once no walk is running, the status-read command makes the next read return the status byte alone. The register values come in as a flat bus and are sampled at the moment of each read. The read data is registered and holds its value between reads.

Top module: `regback_seq`

## Requirements
- R1: After reset the read data output is 0x00, no walk is active and no status read is pending.
- R2: Writing 0xA7 while no walk is active captures the current read mask and starts a walk at the lowest set mask bit. Mask bit k enables register k: bit 0 status, bit 1 byte count low, bit 2 byte count high, bit 3 port A address low, bit 4 port A address high, bit 5 port B address low, bit 6 port B address high. Register k is byte k of `reg_vals`, at bits 8k+7 to 8k.
- R3: Each read during a walk returns the register at the walk position and moves the position to the next higher set mask bit. `rd_data` takes the new value in the cycle after `rd_stb` and holds it until the next read.
- R4: A read of the last enabled register ends the walk. A read made with no walk active and no status read pending returns 0x00.
- R5: While a walk is active, writes of 0xA7 and 0xBF have no effect. The walk goes on from its current position.
- R6: Writing 0xBF while no walk is active makes the next read return the status register (byte 0). That read clears the pending status read.
- R7: Write bytes other than 0xA7 and 0xBF have no effect. Reads may come any number of cycles after the start command. Each read returns the register value present in its own cycle.
- R8: 0xA7 with an all-zero mask ends the walk at once, and the following reads return 0x00. An accepted 0xA7 also cancels a pending status read.
- R9: Changes to the mask input after a walk has started do not change that walk.
- R10: When a write and a read fall in the same cycle, the read is served from the state before the write. An accepted write then sets the state that applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_stb | input | 1 | CPU command write strobe, one cycle per write |
| wr_data | input | 8 | Command byte written by the CPU |
| rd_stb | input | 1 | CPU read strobe, one cycle per read |
| rd_mask | input | 7 | Read mask, bit k enables register k |
| reg_vals | input | 56 | Current register values, byte k is register k |
| rd_data | output | 8 | Registered read data |

## Verification
Sparse masks with gaps are walked with idle cycles and unrelated command bytes placed between the reads. This shows that the position skips exactly the clear bits and is not a plain counter, and that reads need not be back to back. Full, single-bit and all-zero masks separate the first-register, last-register and empty-walk cases. Start and status commands issued during a walk, a mask that changes during a walk, and writes that coincide with reads show whether the block ignores, freezes and orders its state as required. A long run with random strobes, commands, masks and register values is then compared cycle by cycle against a reference model kept in the bench.

// File: rtl/regback_pkg.sv
`timescale 1ns/1ps
package regback_pkg;
  localparam int unsigned NREG = 7;
  localparam int unsigned DW   = 8;
  localparam int unsigned IW   = $clog2(NREG);

  typedef enum logic [0:0] {
    SRC_ZERO = 1'b0,
    SRC_REG  = 1'b1
  } rd_src_e;
endpackage

// File: rtl/regback_rst_sync.sv
`timescale 1ns/1ps
module regback_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/regback_scan.sv
`timescale 1ns/1ps
module regback_scan #(
  parameter int unsigned N  = 7,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  mask,
  input  logic [IW:0]   from_idx,
  output logic          found,
  output logic [IW-1:0] idx
);
  localparam int unsigned FW = IW + 1;

  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = mask[g] && (from_idx <= FW'(g));
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/regback_ctrl.sv
`timescale 1ns/1ps
module regback_ctrl
  import regback_pkg::*;
#(
  parameter int unsigned N         = NREG,
  parameter int unsigned W         = DW,
  parameter logic [7:0]  CMD_START = 8'hA7,
  parameter logic [7:0]  CMD_STAT  = 8'hBF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [W-1:0]           wr_data,
  input  logic                   rd_stb,
  input  logic [N-1:0]           rd_mask,
  output rd_src_e                rd_src,
  output logic [$clog2(N)-1:0]   rd_idx
);
  localparam int unsigned PW = $clog2(N);

  logic          act_q, act_n;
  logic          stat_q, stat_n;
  logic [PW-1:0] ptr_q, ptr_n;
  logic [N-1:0]  mask_q, mask_n;

  logic          first_found, next_found;
  logic [PW-1:0] first_idx, next_idx;
  logic [PW:0]   next_from;

  logic is_start, is_stat;

  assign next_from = {1'b0, ptr_q} + 1'b1;
  assign is_start  = wr_stb && !act_q && (wr_data == W'(CMD_START));
  assign is_stat   = wr_stb && !act_q && (wr_data == W'(CMD_STAT));

  regback_scan #(.N(N), .IW(PW)) i_scan_first (
    .mask     (rd_mask),
    .from_idx ('0),
    .found    (first_found),
    .idx      (first_idx)
  );

  regback_scan #(.N(N), .IW(PW)) i_scan_next (
    .mask     (mask_q),
    .from_idx (next_from),
    .found    (next_found),
    .idx      (next_idx)
  );

  always_comb begin
    act_n  = act_q;
    stat_n = stat_q;
    ptr_n  = ptr_q;
    mask_n = mask_q;
    rd_src = SRC_ZERO;
    rd_idx = '0;
    if (rd_stb) begin
      if (act_q) begin
        rd_src = SRC_REG;
        rd_idx = ptr_q;
        if (next_found) ptr_n = next_idx;
        else            act_n = 1'b0;
      end else if (stat_q) begin
        rd_src = SRC_REG;
        rd_idx = '0;
        stat_n = 1'b0;
      end
    end
    if (is_start) begin
      mask_n = rd_mask;
      stat_n = 1'b0;
      act_n  = first_found;
      ptr_n  = first_idx;
    end else if (is_stat) begin
      stat_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      stat_q <= 1'b0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      act_q  <= act_n;
      stat_q <= stat_n;
      ptr_q  <= ptr_n;
      mask_q <= mask_n;
    end
  end

  // R2: a running walk always points at an enabled register
  a_r2_ptr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> mask_q[ptr_q]);

  // R3: each read in a walk moves strictly upward or ends the walk
  a_r3_ptr_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && rd_stb) |=> (!act_q || (ptr_q > $past(ptr_q))));

  // R5: no read means the walk position and activity stay put
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !rd_stb) |=> (act_q && $stable(ptr_q)));

  // R5: a pending status read never coexists with a walk
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_q && stat_q));

  // R9: the captured mask is frozen while a walk runs
  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> $stable(mask_q));
endmodule

// File: rtl/regback_seq.sv
`timescale 1ns/1ps
module regback_seq
  import regback_pkg::*;
#(
  parameter int unsigned N = NREG,
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [7:0]   wr_data,
  input  logic         rd_stb,
  input  logic [6:0]   rd_mask,
  input  logic [55:0]  reg_vals,
  output logic [7:0]   rd_data
);
  localparam int unsigned PW = $clog2(N);

  logic          rst_s_n;
  rd_src_e       rd_src;
  logic [PW-1:0] rd_idx;
  logic [W-1:0]  rd_q, rd_n;
  logic [W-1:0]  reg_arr [N];

  for (genvar k = 0; k < N; k++) begin : g_unpack
    assign reg_arr[k] = reg_vals[k*W +: W];
  end

  regback_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  regback_ctrl #(.N(N), .W(W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .rd_stb  (rd_stb),
    .rd_mask (rd_mask),
    .rd_src  (rd_src),
    .rd_idx  (rd_idx)
  );

  always_comb begin
    rd_n = rd_q;
    if (rd_stb) begin
      if (rd_src == SRC_REG) rd_n = reg_arr[rd_idx];
      else                   rd_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rd_q <= '0;
    else          rd_q <= rd_n;
  end

  assign rd_data = rd_q;

  // R3: read data holds between reads
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_stb |=> $stable(rd_data));

  // R4: a read with no source yields zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb && (rd_src == SRC_ZERO)) |=> (rd_data == 8'h00));
endmodule

// File: tb/test_regback_seq.sv
`timescale 1ns/1ps
module test_regback_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [7:0]  wr_data;
  logic        rd_stb;
  logic [6:0]  rd_mask;
  logic [55:0] reg_vals;
  logic [7:0]  rd_data;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic       m_act;
  logic       m_stat;
  int         m_ptr;
  logic [6:0] m_mask;
  logic [7:0] m_hold;

  always #2 clk = ~clk;

  regback_seq i_regback_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_stb   (rd_stb),
    .rd_mask  (rd_mask),
    .reg_vals (reg_vals),
    .rd_data  (rd_data)
  );

  function automatic int lowest_from(input logic [6:0] m, input int from);
    for (int k = from; k < 7; k++) if (m[k]) return k;
    return -1;
  endfunction

  function automatic logic [7:0] byte_of(input logic [55:0] v, input int k);
    return v[k*8 +: 8];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s rd_data actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle at a negedge, advance the model, check after the edge
  task automatic step(input string tag, input logic w, input logic [7:0] wd,
                      input logic r, input logic [6:0] m);
    string t;
    int nx;
    logic old_act;
    t = tag;
    wr_stb = w; wr_data = wd; rd_stb = r; rd_mask = m;
    old_act = m_act;
    if (r) begin
      if (m_act) begin
        if (t == "") t = "R3";
        m_hold = byte_of(reg_vals, m_ptr);
        nx = lowest_from(m_mask, m_ptr + 1);
        if (nx >= 0) m_ptr = nx;
        else m_act = 1'b0;
      end else if (m_stat) begin
        if (t == "") t = "R6";
        m_hold = byte_of(reg_vals, 0);
        m_stat = 1'b0;
      end else begin
        if (t == "") t = "R4";
        m_hold = 8'h00;
      end
    end
    if (w && !old_act) begin
      if (wd == 8'hA7) begin
        m_stat = 1'b0;
        m_mask = m;
        nx = lowest_from(m, 0);
        m_act = (nx >= 0);
        m_ptr = (nx >= 0) ? nx : 0;
      end else if (wd == 8'hBF) begin
        m_stat = 1'b1;
      end
    end
    if (t == "") t = "R7";
    @(posedge clk);
    #1;
    check(t, rd_data, m_hold);
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic idle(input string tag, input int n, input logic [6:0] m);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 8'h00, 1'b0, m);
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; wr_stb = 1'b0; wr_data = 8'h00; rd_stb = 1'b0;
    rd_mask = 7'h00; reg_vals = 56'h66_55_44_33_22_11_F0;
    m_act = 1'b0; m_stat = 1'b0; m_ptr = 0; m_mask = '0; m_hold = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, idle read returns zero
    check("R1", rd_data, 8'h00);
    step("R1", 1'b0, 8'h00, 1'b1, 7'h7F);

    // R2 R3 R7: sparse mask with gaps and foreign commands between reads
    step("R2", 1'b1, 8'hA7, 1'b0, 7'b1010110);
    idle("R7", 3, 7'b1010110);
    step("R7", 1'b1, 8'h55, 1'b0, 7'b1010110);
    step("R2", 1'b0, 8'h00, 1'b1, 7'b1010110);
    step("R3", 1'b0, 8'h00, 1'b1, 7'b1010110);
    idle("R3", 2, 7'b1010110);
    step("R7", 1'b1, 8'h00, 1'b0, 7'b1010110);
    step("R3", 1'b0, 8'h00, 1'b1, 7'b1010110);
    step("R4", 1'b0, 8'h00, 1'b1, 7'b1010110);
    step("R4", 1'b0, 8'h00, 1'b1, 7'b1010110);

    // R5: start and status commands during a walk are dropped
    step("R5", 1'b1, 8'hA7, 1'b0, 7'h7F);
    step("R5", 1'b0, 8'h00, 1'b1, 7'h7F);
    step("R5", 1'b0, 8'h00, 1'b1, 7'h7F);
    step("R5", 1'b1, 8'hA7, 1'b0, 7'h01);
    step("R5", 1'b1, 8'hBF, 1'b0, 7'h01);
    for (int i = 0; i < 6; i++) step("R5", 1'b0, 8'h00, 1'b1, 7'h01);

    // R9: mask changes after start are not seen by the walk
    step("R9", 1'b1, 8'hA7, 1'b0, 7'b0000101);
    step("R9", 1'b0, 8'h00, 1'b0, 7'h7F);
    for (int i = 0; i < 3; i++) step("R9", 1'b0, 8'h00, 1'b1, 7'h7F);

    // R6: status read command
    reg_vals[7:0] = 8'h3C;
    step("R6", 1'b1, 8'hBF, 1'b0, 7'h00);
    idle("R6", 2, 7'h00);
    step("R6", 1'b0, 8'h00, 1'b1, 7'h00);
    step("R6", 1'b0, 8'h00, 1'b1, 7'h00);

    // R8: empty mask ends at once and cancels a pending status read
    step("R8", 1'b1, 8'hBF, 1'b0, 7'h00);
    step("R8", 1'b1, 8'hA7, 1'b0, 7'h00);
    step("R8", 1'b0, 8'h00, 1'b1, 7'h00);
    step("R8", 1'b1, 8'hA7, 1'b0, 7'h00);
    step("R8", 1'b0, 8'h00, 1'b1, 7'h7F);

    // R10: same-cycle write and read
    step("R10", 1'b1, 8'hA7, 1'b0, 7'b1000010);
    step("R10", 1'b0, 8'h00, 1'b1, 7'h00);
    step("R10", 1'b1, 8'hA7, 1'b1, 7'h7F);
    step("R10", 1'b0, 8'h00, 1'b1, 7'h7F);
    step("R10", 1'b1, 8'hBF, 1'b0, 7'h00);
    step("R10", 1'b1, 8'hA7, 1'b1, 7'b0001000);
    step("R10", 1'b0, 8'h00, 1'b1, 7'h00);
    step("R10", 1'b0, 8'h00, 1'b1, 7'h00);

    // R7 R3: register values sampled at read time
    step("R7", 1'b1, 8'hA7, 1'b0, 7'b0100000);
    reg_vals[47:40] = 8'h9E;
    step("R7", 1'b0, 8'h00, 1'b1, 7'h00);

    // random phase
    for (int n = 0; n < 20000; n++) begin
      logic w, r;
      logic [7:0] wd;
      logic [6:0] m;
      int sel;
      w = ($urandom_range(0, 3) == 0);
      sel = $urandom_range(0, 9);
      wd = (sel < 4) ? 8'hA7 : (sel < 7) ? 8'hBF : 8'($urandom);
      r = ($urandom_range(0, 1) == 0);
      m = ($urandom_range(0, 7) == 0) ? 7'h00 : 7'($urandom);
      reg_vals = {$urandom, $urandom} [55:0];
      step("", w, wd, r, m);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule